// File: doc/BRIEF.md
# PS/2 Host Port Controller

This block is a single-channel PS/2 host port. It watches and drives an open-drain clock line and an open-drain data line through separate output-enable pins: when an enable pin is high the line is pulled low, otherwise the line is released. A direction bit chooses its mode. In receive mode it collects frames clocked by the attached device. In transmit mode it issues a request-to-send and then shifts out a byte while the device supplies the clock. Software sees three byte-wide registers on a simple synchronous register port. The data register is written to send and read to collect. The control register holds direction, enable, parity mode and stop-bit mode. The status register combines live state with sticky error and timeout flags that are cleared by writing one.

A frame has eleven bits, in this order: a low start bit, eight data bits with the least significant bit first, a parity bit, and a stop bit. The device clock is synchronised with two flops, and a bit is taken on each falling edge that is detected after synchronisation. A received byte remains in the data register until it is read. While it waits, the controller holds the clock line low, so the device cannot send another frame. The register port does not stall. Reads return data combinationally in the same cycle, and writes take effect at the next clock edge. There is no back-pressure on either side apart from that clock hold. The inhibit time and the three timeouts are parameters, counted in system clock cycles.

Top module: `ps2_port_ctrl`

## Requirements
- R1: Register address 0 is the data register. A read returns the last good received byte and clears the receive-ready flag. A write in transmit mode, while enabled and while the transmitter is idle, starts a transmission of that byte.
- R2: Control register (address 1) layout: bit 0 is direction (0 receive, 1 transmit), bit 1 is enable, bits 3:2 are parity mode and bits 5:4 are stop mode. A received frame is a low start bit followed by ten more bits, each sampled on a falling clock edge, data LSB first. A frame with no error loads the byte and sets receive-ready.
- R3: Parity mode 0 requires an odd count of ones over the data and parity bits, mode 1 requires an even count, and modes 2 and 3 skip the check. A violation sets the parity-error flag, and the byte is not loaded.
- R4: Stop mode 0 requires a high stop bit, mode 1 requires a low stop bit, and modes 2 and 3 skip the check. A violation sets the framing-error flag, and the byte is not loaded.
- R5: Status register (address 2) bits: 0 receive-ready, 1 receive timeout, 2 parity error, 3 framing error, 4 transmitter idle, 5 transmit timeout, 6 receiver busy, 7 transmit-start timeout. Bits 0, 4 and 6 show live state.
- R6: Writing the status register clears each of bits 1, 2, 3, 5 and 7 whose write-data bit is one, and no other bit. A write of zero changes nothing.
- R7: While receive-ready is set in enabled receive mode, the clock output-enable is held high. It drops once the byte is read.
- R8: A transmission first pulls the clock low for exactly INHIBIT_CYC cycles. It then releases the clock and pulls the data line low. Before each of the following eleven falling edges the data line carries, in turn, the start bit 0, data LSB first, parity, and a released stop bit. Parity is even for mode 1 and odd for every other mode. After the eleventh falling edge the transmitter is idle.
- R9: If no falling edge arrives within TX_START_CYC cycles after the data request, the transmission is abandoned and status bit 7 is set.
- R10: If a gap between falling edges during a transmission reaches TX_GAP_CYC cycles, the transmission is abandoned and status bit 5 is set.
- R11: If a gap between falling edges during a reception reaches RX_GAP_CYC cycles, the frame is dropped, status bit 1 is set and the receiver becomes idle.
- R12: With enable at 0, line activity changes nothing: no frame is received, both output-enables stay low, and the status register reads 0x10.
- R13: The irq output is high exactly when receive-ready or any of the five sticky flags is set.
- R14: After reset the status register reads 0x10, the data register reads 0, and irq and both output-enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has side effects on address 0) |
| reg_addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on reg_addr |
| ps2_clk_i | input | 1 | Level of the PS/2 clock line |
| ps2_dat_i | input | 1 | Level of the PS/2 data line |
| ps2_clk_oe | output | 1 | Pull clock line low when high |
| ps2_dat_oe | output | 1 | Pull data line low when high |
| irq | output | 1 | Level interrupt |

## Verification
A receiver that is out of step with the frame shows up at the data register as a shifted byte, or in the status register as a spurious parity or framing flag. Either appears in the first status read after the eleventh falling edge. A stuck transmit sequencer shows up within INHIBIT_CYC cycles as a clock hold of the wrong length, or as a wrong bit on the data line before some falling edge. If a timeout counter fails to clear, it sets a timeout flag in the middle of a healthy frame, and that flag is visible in the next status read. A broken clear path for receive-ready leaves the clock output-enable high after the data register has been read.

// File: rtl/ps2_pkg.sv
package ps2_pkg;
  typedef enum logic [1:0] {PAR_ODD = 2'd0, PAR_EVEN = 2'd1, PAR_SKIP = 2'd2, PAR_RSVD = 2'd3} par_mode_t;
  typedef enum logic [1:0] {STP_HIGH = 2'd0, STP_LOW = 2'd1, STP_SKIP = 2'd2, STP_RSVD = 2'd3} stop_mode_t;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam int FRAME_TAIL = 10;  // bits after the start bit
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_line,
  input  logic dat_line,
  output logic dat_s,
  output logic fall
);
  logic [STAGES-1:0] clk_q, dat_q;
  logic clk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q    <= '1;
      dat_q    <= '1;
      clk_prev <= 1'b1;
    end else begin
      clk_q    <= {clk_q[STAGES-2:0], clk_line};
      dat_q    <= {dat_q[STAGES-2:0], dat_line};
      clk_prev <= clk_q[STAGES-1];
    end
  end

  assign dat_s = dat_q[STAGES-1];
  assign fall  = clk_prev & ~clk_q[STAGES-1];
endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame
  import ps2_pkg::*;
#(
  parameter int GAP_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       block,
  input  logic       fall,
  input  logic       dat_s,
  input  par_mode_t  par_mode,
  input  stop_mode_t stop_mode,
  output logic       busy,
  output logic       done,
  output logic       err_par,
  output logic       err_frm,
  output logic       timeout,
  output logic [7:0] data
);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam int CW = $clog2(FRAME_TAIL + 1);

  logic [FRAME_TAIL-1:0] sh, frame_w;
  logic [CW-1:0] cnt;
  logic [GW-1:0] gap;
  logic ones_odd, p_bad, s_bad;

  assign frame_w  = {dat_s, sh[FRAME_TAIL-1:1]};
  assign ones_odd = ^frame_w[8:0];
  always_comb begin
    unique case (par_mode)
      PAR_ODD:  p_bad = ~ones_odd;
      PAR_EVEN: p_bad = ones_odd;
      default:  p_bad = 1'b0;
    endcase
    unique case (stop_mode)
      STP_HIGH: s_bad = ~frame_w[9];
      STP_LOW:  s_bad = frame_w[9];
      default:  s_bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; gap <= '0; sh <= '0; data <= '0;
      done <= 1'b0; err_par <= 1'b0; err_frm <= 1'b0; timeout <= 1'b0;
    end else begin
      done <= 1'b0; err_par <= 1'b0; err_frm <= 1'b0; timeout <= 1'b0;
      if (!en) begin
        busy <= 1'b0;
      end else if (!busy) begin
        if (fall && !dat_s && !block) begin
          busy <= 1'b1; cnt <= '0; gap <= '0;
        end
      end else if (fall) begin
        gap <= '0;
        sh  <= frame_w;
        cnt <= cnt + 1'b1;
        if (cnt == CW'(FRAME_TAIL - 1)) begin
          busy    <= 1'b0;
          err_par <= p_bad;
          err_frm <= s_bad;
          if (!p_bad && !s_bad) begin
            done <= 1'b1;
            data <= frame_w[7:0];
          end
        end
      end else if (gap == GW'(GAP_CYC - 1)) begin
        busy <= 1'b0; timeout <= 1'b1;
      end else begin
        gap <= gap + 1'b1;
      end
    end
  end

  assert_gap_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (gap < GW'(GAP_CYC)));
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/ps2_tx_frame.sv
module ps2_tx_frame
  import ps2_pkg::*;
#(
  parameter int INHIBIT_CYC  = 16,
  parameter int TX_START_CYC = 64,
  parameter int TX_GAP_CYC   = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       start,
  input  logic [7:0] data,
  input  par_mode_t  par_mode,
  input  logic       fall,
  output logic       clk_oe,
  output logic       dat_oe,
  output logic       idle,
  output logic       timeout,
  output logic       st_timeout
);
  localparam int TMAX = (INHIBIT_CYC > TX_START_CYC) ?
                        ((INHIBIT_CYC > TX_GAP_CYC) ? INHIBIT_CYC : TX_GAP_CYC) :
                        ((TX_START_CYC > TX_GAP_CYC) ? TX_START_CYC : TX_GAP_CYC);
  localparam int TW = $clog2(TMAX + 1);
  localparam int NW = $clog2(FRAME_TAIL + 1);

  typedef enum logic [1:0] {T_IDLE, T_INHIB, T_REQ, T_SHIFT} tstate_t;
  tstate_t st;
  logic [TW-1:0] tmr;
  logic [NW-1:0] nb;
  logic [FRAME_TAIL-1:0] sh;
  logic outbit, par_bit;

  assign par_bit = (par_mode == PAR_EVEN) ? ^data : ~^data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= T_IDLE; tmr <= '0; nb <= '0; sh <= '0; outbit <= 1'b1;
      timeout <= 1'b0; st_timeout <= 1'b0;
    end else begin
      timeout <= 1'b0; st_timeout <= 1'b0;
      if (!en) begin
        st <= T_IDLE;
      end else begin
        unique case (st)
          T_IDLE: if (start) begin
            st <= T_INHIB; tmr <= '0;
            sh <= {1'b1, par_bit, data};
          end
          T_INHIB: begin
            tmr <= tmr + 1'b1;
            if (tmr == TW'(INHIBIT_CYC - 1)) begin
              st <= T_REQ; tmr <= '0;
            end
          end
          T_REQ: begin
            tmr <= tmr + 1'b1;
            if (fall) begin
              st <= T_SHIFT; tmr <= '0; nb <= NW'(1);
              outbit <= sh[0]; sh <= sh >> 1;
            end else if (tmr == TW'(TX_START_CYC - 1)) begin
              st <= T_IDLE; st_timeout <= 1'b1;
            end
          end
          T_SHIFT: begin
            tmr <= tmr + 1'b1;
            if (fall) begin
              tmr <= '0;
              if (nb == NW'(FRAME_TAIL)) begin
                st <= T_IDLE; outbit <= 1'b1;
              end else begin
                outbit <= sh[0]; sh <= sh >> 1; nb <= nb + 1'b1;
              end
            end else if (tmr == TW'(TX_GAP_CYC - 1)) begin
              st <= T_IDLE; timeout <= 1'b1; outbit <= 1'b1;
            end
          end
          default: st <= T_IDLE;
        endcase
      end
    end
  end

  assign clk_oe = (st == T_INHIB);
  assign dat_oe = (st == T_REQ) | ((st == T_SHIFT) & ~outbit);
  assign idle   = (st == T_IDLE);

  assert_release_with_request_R8: assert property (@(posedge clk) disable iff (!rst_n || !en)
    $fell(clk_oe) |-> dat_oe);
  assert_no_timeout_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_timeout || timeout) |-> idle);
endmodule

// File: rtl/ps2_port_ctrl.sv
module ps2_port_ctrl
  import ps2_pkg::*;
#(
  parameter int INHIBIT_CYC  = 16,
  parameter int TX_START_CYC = 64,
  parameter int TX_GAP_CYC   = 64,
  parameter int RX_GAP_CYC   = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       ps2_clk_oe,
  output logic       ps2_dat_oe,
  output logic       irq
);
  logic [5:0] ctrl;
  logic [7:0] rx_buf;
  logic rdy, f_rxto, f_par, f_frm, f_txto, f_txst;
  logic dat_s, fall;
  logic rx_en, tx_en, rx_busy, rx_done, rx_perr, rx_ferr, rx_to;
  logic [7:0] rx_data;
  logic tx_clk_oe, tx_dat_oe, tx_idle, tx_to, tx_st_to, tx_start;
  logic [7:0] stat;
  logic wr_stat, rd_data;

  assign rx_en    = ctrl[1] & ~ctrl[0];
  assign tx_en    = ctrl[1] & ctrl[0];
  assign tx_start = reg_wr && reg_addr == ADDR_DATA && tx_en && tx_idle;
  assign wr_stat  = reg_wr && reg_addr == ADDR_STAT;
  assign rd_data  = reg_rd && reg_addr == ADDR_DATA;

  ps2_line_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .clk_line(ps2_clk_i), .dat_line(ps2_dat_i),
    .dat_s(dat_s), .fall(fall));

  ps2_rx_frame #(.GAP_CYC(RX_GAP_CYC)) rx_i (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .block(rdy), .fall(fall), .dat_s(dat_s),
    .par_mode(par_mode_t'(ctrl[3:2])), .stop_mode(stop_mode_t'(ctrl[5:4])),
    .busy(rx_busy), .done(rx_done), .err_par(rx_perr), .err_frm(rx_ferr),
    .timeout(rx_to), .data(rx_data));

  ps2_tx_frame #(.INHIBIT_CYC(INHIBIT_CYC), .TX_START_CYC(TX_START_CYC),
                 .TX_GAP_CYC(TX_GAP_CYC)) tx_i (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .start(tx_start), .data(reg_wdata),
    .par_mode(par_mode_t'(ctrl[3:2])), .fall(fall), .clk_oe(tx_clk_oe),
    .dat_oe(tx_dat_oe), .idle(tx_idle), .timeout(tx_to), .st_timeout(tx_st_to));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; rx_buf <= '0; rdy <= 1'b0;
      f_rxto <= 1'b0; f_par <= 1'b0; f_frm <= 1'b0; f_txto <= 1'b0; f_txst <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CTRL) ctrl <= reg_wdata[5:0];
      if (rx_done) begin
        rdy <= 1'b1; rx_buf <= rx_data;
      end else if (rd_data) begin
        rdy <= 1'b0;
      end
      f_rxto <= rx_to    | (f_rxto & ~(wr_stat & reg_wdata[1]));
      f_par  <= rx_perr  | (f_par  & ~(wr_stat & reg_wdata[2]));
      f_frm  <= rx_ferr  | (f_frm  & ~(wr_stat & reg_wdata[3]));
      f_txto <= tx_to    | (f_txto & ~(wr_stat & reg_wdata[5]));
      f_txst <= tx_st_to | (f_txst & ~(wr_stat & reg_wdata[7]));
    end
  end

  assign stat = {f_txst, rx_busy, f_txto, tx_idle, f_frm, f_par, f_rxto, rdy};

  always_comb begin
    unique case (reg_addr)
      ADDR_DATA: reg_rdata = rx_buf;
      ADDR_CTRL: reg_rdata = {2'b00, ctrl};
      ADDR_STAT: reg_rdata = stat;
      default:   reg_rdata = 8'h00;
    endcase
  end

  assign ps2_clk_oe = tx_clk_oe | (rx_en & rdy);
  assign ps2_dat_oe = tx_dat_oe;
  assign irq = rdy | f_rxto | f_par | f_frm | f_txto | f_txst;

  assert_read_clears_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_done) |=> !rdy);
  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[1] && !rx_to) |=> !f_rxto);
  assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[1] |=> (!rx_busy && tx_idle));
  assert_one_direction_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_busy && !tx_idle));
endmodule

// File: tb/ps2_port_ctrl_tb.sv
module ps2_port_ctrl_tb_top;
  localparam int INH = 16, TST = 64, TGAP = 64, RGAP = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic ps2_clk_oe, ps2_dat_oe, irq;
  logic dev_clk = 1'b1, dev_dat = 1'b1;
  logic line_clk, line_dat;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  assign line_clk = dev_clk & ~ps2_clk_oe;
  assign line_dat = dev_dat & ~ps2_dat_oe;

  always #4 clk = ~clk;

  ps2_port_ctrl #(.INHIBIT_CYC(INH), .TX_START_CYC(TST), .TX_GAP_CYC(TGAP),
                  .RX_GAP_CYC(RGAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ps2_clk_i(line_clk),
    .ps2_dat_i(line_dat), .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; #1;
  endtask

  task automatic reg_peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1; d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0; #1;
  endtask

  // device-driven frame: bits sent in order, one falling edge each
  task automatic dev_send(input logic [10:0] bits, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      dev_dat = bits[i];
      wait_cyc(5); dev_clk = 1'b0;
      wait_cyc(10); dev_clk = 1'b1;
      wait_cyc(5);
    end
    dev_dat = 1'b1;
  endtask

  function automatic logic [10:0] mk_frame(input logic [7:0] d, input logic p, input logic s);
    return {s, p, d, 1'b0};
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    logic [7:0] dset [4] = '{8'h00, 8'hA5, 8'hFF, 8'h3C};
    wait_cyc(4); rst_n = 1'b1; wait_cyc(2);

    // R14 reset state
    reg_peek(2'd2, rv); chk("R14 status", rv, 8'h10);
    reg_peek(2'd0, rv); chk("R14 data", rv, 8'h00);
    chk("R14 irq/oe", {irq, ps2_clk_oe, ps2_dat_oe}, 0);

    // R12 disabled: frame ignored
    dev_send(mk_frame(8'h5A, 1'b1, 1'b1), 11); wait_cyc(10);
    reg_peek(2'd2, rv); chk("R12 status disabled", rv, 8'h10);
    chk("R12 oe disabled", {ps2_clk_oe, ps2_dat_oe}, 0);

    // R2 R3 R4 receive sweep
    for (int pm = 0; pm < 3; pm++)
      for (int sm = 0; sm < 3; sm++) begin
        reg_write(2'd1, 8'((sm << 4) | (pm << 2) | 2));
        reg_peek(2'd1, rv); chk("R2 ctrl readback", rv, (sm << 4) | (pm << 2) | 2);
        for (int di = 0; di < 4; di++)
          for (int pb = 0; pb < 2; pb++)
            for (int sb = 0; sb < 2; sb++) begin
              int ones; bit perr, ferr, ok; int exp;
              ones = $countones(dset[di]) + pb;
              perr = (pm == 0) ? (ones % 2 == 0) : (pm == 1) ? (ones % 2 == 1) : 1'b0;
              ferr = (sm == 0) ? (sb == 0) : (sm == 1) ? (sb == 1) : 1'b0;
              ok = !perr && !ferr;
              exp = 8'h10 | int'(ok) | (int'(perr) << 2) | (int'(ferr) << 3);
              dev_send(mk_frame(dset[di], pb[0], sb[0]), 11); wait_cyc(6);
              reg_peek(2'd2, rv); chk("R3/R4 rx status", rv, exp);
              chk("R13 irq", irq, (exp != 8'h10));
              if (ok) begin
                chk("R7 clock held", ps2_clk_oe, 1);
                reg_read(2'd0, rv); chk("R1 rx data", rv, dset[di]);
                chk("R7 clock released", ps2_clk_oe, 0);
                reg_peek(2'd2, rv); chk("R1 ready cleared", rv[0], 0);
              end
              reg_write(2'd2, 8'hAE);
            end
      end

    // R11 receive timeout, R5 busy bit, R6 write-one-to-clear
    reg_write(2'd1, 8'h02);
    dev_send(mk_frame(8'h81, 1'b1, 1'b1), 3);
    reg_peek(2'd2, rv); chk("R5 rx busy", rv, 8'h50);
    wait_cyc(RGAP + 10);
    reg_peek(2'd2, rv); chk("R11 rx timeout", rv, 8'h12);
    chk("R13 irq on timeout", irq, 1);
    reg_write(2'd2, 8'h00);
    reg_peek(2'd2, rv); chk("R6 write zero", rv, 8'h12);
    reg_write(2'd2, 8'hFF);
    reg_peek(2'd2, rv); chk("R6 clear mask", rv, 8'h10);

    // R8 transmit sweep
    for (int pm = 0; pm < 4; pm++)
      for (int di = 0; di < 4; di++) begin
        int hold; logic [10:0] got; logic [10:0] expf; logic par;
        reg_write(2'd1, 8'((pm << 2) | 3));
        reg_write(2'd0, dset[di]);
        hold = 0;
        while (ps2_clk_oe) begin hold++; @(negedge clk); #1; end
        chk("R8 inhibit length", hold, INH);
        chk("R8 request data low", ps2_dat_oe, 1);
        reg_peek(2'd2, rv); chk("R5 tx busy", rv[4], 0);
        for (int k = 0; k < 11; k++) begin
          wait_cyc(5); #1; got[k] = line_dat;
          dev_clk = 1'b0; wait_cyc(10); dev_clk = 1'b1;
        end
        wait_cyc(8);
        par = (pm == 1) ? ^dset[di] : ~^dset[di];
        expf = {1'b1, par, dset[di], 1'b0};
        chk("R8 tx bits", got, expf);
        reg_peek(2'd2, rv); chk("R8 tx idle after", rv, 8'h10);
      end

    // R10 transmit timeout
    reg_write(2'd1, 8'h03);
    reg_write(2'd0, 8'h77);
    wait_cyc(INH + 2);
    for (int k = 0; k < 3; k++) begin
      wait_cyc(5); dev_clk = 1'b0; wait_cyc(10); dev_clk = 1'b1;
    end
    wait_cyc(TGAP + 10);
    reg_peek(2'd2, rv); chk("R10 tx timeout", rv, 8'h30);
    chk("R10 data released", ps2_dat_oe, 0);
    reg_write(2'd2, 8'h20);

    // R9 transmit start timeout
    reg_write(2'd0, 8'h12);
    wait_cyc(INH + TST + 10);
    reg_peek(2'd2, rv); chk("R9 start timeout", rv, 8'h90);
    chk("R13 irq tx", irq, 1);
    reg_write(2'd2, 8'h80);
    reg_peek(2'd2, rv); chk("R6 clear bit7", rv, 8'h10);
    chk("R9 lines released", {ps2_clk_oe, ps2_dat_oe}, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule